// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block is the integer adder of a RISC execution stage. It takes two register operands and an immediate and, through one shared W-bit adder, computes plain sums, immediate sums, carry-consuming extended sums, add-to-minus-one and add-to-zero forms, their subtract-from counterparts, and two's-complement negation. The result is combinational. Three architectural flags sit beside it: a carry flag, an overflow flag and a sticky summary-overflow flag. They change on a clock edge only when the issue strobe is high.

Each operation may also ask for a 4-bit record field that classifies the result as negative, positive or zero and carries the summary-overflow bit. Two further opcodes serve the flags themselves. One reads them out on the result bus and the other clears them. A core issues one operation per cycle with `valid_i` high. Extended forms chain multi-word arithmetic through the carry flag. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `addsub_flag_unit`

## Requirements
- R1: Add family, with result = A+B for op 0 (plain) and op 1 (carrying), A+B+CA for op 2 (extended), A+IMM for op 3 and op 4 (immediate, carrying), A+CA-1 for op 5 and A+CA for op 6, all modulo 2^W.
- R2: Subtract-from family, with result = B-A for op 7 and op 8 (carrying), B+~A+CA for op 9, IMM-A for op 10, ~A+CA-1 for op 11 and ~A+CA for op 12, all modulo 2^W.
- R3: On a valid edge, ops 1, 2, 4, 5, 6, 8, 9, 10, 11 and 12 load the carry flag with the unsigned carry out of bit W-1 of the sum. For subtract-from this means carry = 1 when the result is not greater than the minuend, i.e. when no borrow occurs. Ops 0, 3, 7 and 13 leave the carry flag unchanged.
- R4: Extended forms consume the carry flag. For op 2 the new carry is 1 when the result is below A, or when CA was 1 and the result equals A.
- R5: When overflow-enable is 1 on a valid edge of an arithmetic op (0 to 13) that has signed overflow, both the overflow and summary-overflow flags are set. If there is no overflow, only the overflow flag is cleared. When overflow-enable is 0, both flags are unchanged. Summary-overflow is cleared only by op 15 or reset.
- R6: Op 13 returns -A. For A = 0x80000000 it returns A unchanged, and with overflow-enable set it also sets the overflow and summary-overflow flags.
- R7: With record-enable high, record bits [3:1] are 100 for a negative signed result, 010 for positive and 001 for zero. Bit 0 is the summary-overflow value after this operation's own flag update. With record-enable low the field is 0.
- R8: Op 14 places summary-overflow, overflow and carry on result bits 3, 2 and 1, with all other bits 0. It leaves the flags unchanged.
- R9: Op 15 clears all three flags on a valid edge, and its result reads 0.
- R10: Flags change only on a clock edge with `valid_i` high. Reset clears all flags. The flag outputs show the registered values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| valid_i | input | 1 | Issue strobe, lets the flags update this edge |
| op_i | input | 4 | Operation select (codes in R1, R2, R6, R8, R9) |
| opa_i | input | W | Operand A |
| opb_i | input | W | Operand B |
| imm_i | input | W | Immediate operand |
| ovf_en_i | input | 1 | Overflow-enable for this operation |
| rec_en_i | input | 1 | Record-enable for this operation |
| result_o | output | W | Combinational result |
| rec_o | output | 4 | Record field |
| carry_o | output | 1 | Registered carry flag |
| ovf_o | output | 1 | Registered overflow flag |
| sumovf_o | output | 1 | Registered sticky summary-overflow flag |

## Verification
The assertions assume that `op_i`, the operands and the enables are stable and known around each rising edge. They are checked only after the internally synchronised reset has been released. The bench therefore changes every input on the falling edge and issues nothing until several cycles after `rst_n` rises. Every one of the sixteen opcodes is defined, so any value on `op_i` is legal. The stimulus still covers each code on purpose, with operands picked at the carry, borrow and signed-overflow boundaries.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_ADDE   = 4'd2,
    OP_ADDI   = 4'd3,
    OP_ADDIC  = 4'd4,
    OP_ADDME  = 4'd5,
    OP_ADDZE  = 4'd6,
    OP_SUBF   = 4'd7,
    OP_SUBFC  = 4'd8,
    OP_SUBFE  = 4'd9,
    OP_SUBFI  = 4'd10,
    OP_SUBFME = 4'd11,
    OP_SUBFZE = 4'd12,
    OP_NEG    = 4'd13,
    OP_FLGRD  = 4'd14,
    OP_FLGCLR = 4'd15
  } addsub_op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ca;
  } addsub_flags_t;

endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] imm_i,
  input  logic         ca_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic         cin_o,
  output logic         upd_ca_o,
  output logic         arith_o,
  output logic         flag_rd_o,
  output logic         flag_clr_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

  always_comb begin
    x_o        = ALL_ZERO;
    y_o        = ALL_ZERO;
    cin_o      = 1'b0;
    upd_ca_o   = 1'b0;
    arith_o    = 1'b1;
    flag_rd_o  = 1'b0;
    flag_clr_o = 1'b0;
    unique case (op_i)
      OP_ADD:    begin x_o = opa_i;  y_o = opb_i;                  end
      OP_ADDC:   begin x_o = opa_i;  y_o = opb_i;  upd_ca_o = 1'b1; end
      OP_ADDE:   begin x_o = opa_i;  y_o = opb_i;  cin_o = ca_i; upd_ca_o = 1'b1; end
      OP_ADDI:   begin x_o = opa_i;  y_o = imm_i;                  end
      OP_ADDIC:  begin x_o = opa_i;  y_o = imm_i;  upd_ca_o = 1'b1; end
      OP_ADDME:  begin x_o = opa_i;  y_o = ALL_ONES; cin_o = ca_i; upd_ca_o = 1'b1; end
      OP_ADDZE:  begin x_o = opa_i;  y_o = ALL_ZERO; cin_o = ca_i; upd_ca_o = 1'b1; end
      OP_SUBF:   begin x_o = ~opa_i; y_o = opb_i;  cin_o = 1'b1;   end
      OP_SUBFC:  begin x_o = ~opa_i; y_o = opb_i;  cin_o = 1'b1; upd_ca_o = 1'b1; end
      OP_SUBFE:  begin x_o = ~opa_i; y_o = opb_i;  cin_o = ca_i; upd_ca_o = 1'b1; end
      OP_SUBFI:  begin x_o = ~opa_i; y_o = imm_i;  cin_o = 1'b1; upd_ca_o = 1'b1; end
      OP_SUBFME: begin x_o = ~opa_i; y_o = ALL_ONES; cin_o = ca_i; upd_ca_o = 1'b1; end
      OP_SUBFZE: begin x_o = ~opa_i; y_o = ALL_ZERO; cin_o = ca_i; upd_ca_o = 1'b1; end
      OP_NEG:    begin x_o = ~opa_i; y_o = ALL_ZERO; cin_o = 1'b1; end
      OP_FLGRD:  begin arith_o = 1'b0; flag_rd_o = 1'b1;  end
      OP_FLGCLR: begin arith_o = 1'b0; flag_clr_o = 1'b1; end
      default:   begin arith_o = 1'b0; end
    endcase
  end

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  localparam int SW = W + 1;

  logic [SW-1:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, x_i} + {1'b0, y_i} + {{(SW-1){1'b0}}, cin_i};
    sum_o    = wide_sum[W-1:0];
    cout_o   = wide_sum[W];
    // signed overflow: like-signed inputs producing a result of the other sign
    ovf_o    = (x_i[W-1] == y_i[W-1]) && (wide_sum[W-1] != x_i[W-1]);
  end

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
  import addsub_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          upd_ca_i,
  input  logic          arith_i,
  input  logic          clr_i,
  input  logic          ovf_en_i,
  input  logic          cout_i,
  input  logic          ovf_i,
  output addsub_flags_t flags_q_o,
  output addsub_flags_t flags_d_o
);

  addsub_flags_t flags_q;
  addsub_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (valid_i) begin
      if (clr_i) begin
        flags_d = '0;
      end else begin
        if (upd_ca_i) flags_d.ca = cout_i;
        if (arith_i && ovf_en_i) begin
          flags_d.ov = ovf_i;
          if (ovf_i) flags_d.so = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (valid_i) begin
      flags_q <= flags_d;
    end
  end

  assign flags_q_o = flags_q;
  assign flags_d_o = flags_d;

endmodule

// File: rtl/addsub_record_gen.sv
module addsub_record_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] result_i,
  input  logic         so_next_i,
  input  logic         rec_en_i,
  output logic [3:0]   rec_o
);

  logic is_zero;
  logic is_neg;
  logic is_pos;

  always_comb begin
    is_zero = ~|result_i;
    is_neg  = result_i[W-1];
    is_pos  = ~is_zero & ~is_neg;
    if (rec_en_i) rec_o = {is_neg, is_pos, is_zero, so_next_i};
    else          rec_o = 4'b0000;
  end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
  import addsub_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] imm_i,
  input  logic         ovf_en_i,
  input  logic         rec_en_i,
  output logic [W-1:0] result_o,
  output logic [3:0]   rec_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         sumovf_o
);

  localparam int PAD = W - 4;

  // reset: asserted asynchronously, released through a synchroniser
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic [W-1:0]  x, y, sum;
  logic          cin, cout, ovf_raw;
  logic          upd_ca, arith, flag_rd, flag_clr;
  addsub_flags_t flags_q, flags_d;

  addsub_operand_sel #(.W(W)) u_sel (
    .op_i       (op_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .imm_i      (imm_i),
    .ca_i       (flags_q.ca),
    .x_o        (x),
    .y_o        (y),
    .cin_o      (cin),
    .upd_ca_o   (upd_ca),
    .arith_o    (arith),
    .flag_rd_o  (flag_rd),
    .flag_clr_o (flag_clr)
  );

  addsub_core #(.W(W)) u_core (
    .x_i    (x),
    .y_i    (y),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf_raw)
  );

  addsub_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .valid_i   (valid_i),
    .upd_ca_i  (upd_ca),
    .arith_i   (arith),
    .clr_i     (flag_clr),
    .ovf_en_i  (ovf_en_i),
    .cout_i    (cout),
    .ovf_i     (ovf_raw),
    .flags_q_o (flags_q),
    .flags_d_o (flags_d)
  );

  always_comb begin
    if (flag_rd) result_o = {{PAD{1'b0}}, flags_q.so, flags_q.ov, flags_q.ca, 1'b0};
    else         result_o = sum;
  end

  addsub_record_gen #(.W(W)) u_rec (
    .result_i  (result_o),
    .so_next_i (flags_d.so),
    .rec_en_i  (rec_en_i),
    .rec_o     (rec_o)
  );

  assign carry_o  = flags_q.ca;
  assign ovf_o    = flags_q.ov;
  assign sumovf_o = flags_q.so;

endmodule

// File: rtl/addsub_flag_chk.sv
module addsub_flag_chk
  import addsub_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic         ovf_en_i,
  input logic         rec_en_i,
  input logic [W-1:0] result_o,
  input logic [3:0]   rec_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         sumovf_o
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam int           PAD     = W - 4;

  assert_sticky_so_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sumovf_o && !(valid_i && op_i == OP_FLGCLR)) |=> sumovf_o);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_FLGCLR) |=> (!carry_o && !ovf_o && !sumovf_o));

  assert_neg_min_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_NEG && ovf_en_i && opa_i == MIN_NEG) |=> (ovf_o && sumovf_o));

  assert_neg_min_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NEG && opa_i == MIN_NEG) |-> (result_o == MIN_NEG));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable({sumovf_o, ovf_o, carry_o}));

  assert_record_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en_i |-> ($countones(rec_o[3:1]) == 1));

  assert_record_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en_i |-> (rec_o == 4'b0000));

  assert_flag_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FLGRD) |-> (result_o == {{PAD{1'b0}}, sumovf_o, ovf_o, carry_o, 1'b0}));

  assert_flag_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == OP_FLGRD) |=> $stable({sumovf_o, ovf_o, carry_o}));

  assert_carry_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op_i == OP_ADD || op_i == OP_ADDI || op_i == OP_SUBF || op_i == OP_NEG))
    |=> $stable(carry_o));

endmodule

bind addsub_flag_unit addsub_flag_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .opa_i    (opa_i),
  .ovf_en_i (ovf_en_i),
  .rec_en_i (rec_en_i),
  .result_o (result_o),
  .rec_o    (rec_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .sumovf_o (sumovf_o)
);

// File: tb/sim_addsub_flag_unit.sv
module sim_addsub_flag_unit;
  import addsub_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i;
  logic [3:0]   op_i;
  logic [W-1:0] opa_i, opb_i, imm_i;
  logic         ovf_en_i, rec_en_i;
  logic [W-1:0] result_o;
  logic [3:0]   rec_o;
  logic         carry_o, ovf_o, sumovf_o;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_flag_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .ovf_en_i(ovf_en_i), .rec_en_i(rec_en_i),
    .result_o(result_o), .rec_o(rec_o),
    .carry_o(carry_o), .ovf_o(ovf_o), .sumovf_o(sumovf_o)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // present an operation at the falling edge; combinational outputs valid after #1
  task automatic issue(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] imm, input logic oe, input logic re, input logic v);
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; imm_i = imm;
    ovf_en_i = oe; rec_en_i = re; valid_i = v;
    #1;
  endtask

  // let the rising edge take the flags, then drop the strobe
  task automatic commit;
    @(posedge clk);
    #1;
    valid_i = 1'b0;
  endtask

  // flags compared as {so, ov, ca}
  task automatic op_chk(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic [W-1:0] imm, input logic oe,
                        input logic [W-1:0] exp_res, input logic [2:0] exp_flags);
    issue(op, a, b, imm, oe, 1'b0, 1'b1);
    chk({tag, " result"}, result_o, exp_res);
    commit();
    chk({tag, " flags"}, {29'd0, sumovf_o, ovf_o, carry_o}, {29'd0, exp_flags});
  endtask

  task automatic clear_flags;
    op_chk("R9 clear", OP_FLGCLR, 32'h1234, 32'h5678, 32'h0, 1'b0, 32'h0, 3'b000);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; valid_i = 1'b0; op_i = OP_ADD;
    opa_i = '0; opb_i = '0; imm_i = '0; ovf_en_i = 1'b0; rec_en_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset flags", {29'd0, sumovf_o, ovf_o, carry_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    issue(OP_FLGRD, '0, '0, '0, 1'b0, 1'b0, 1'b0);
    chk("R8 read after reset", result_o, 32'd0);
  endtask

  task automatic t_add_family;
    clear_flags();
    op_chk("R1 add", OP_ADD, 32'd5, 32'd7, 32'd0, 1'b0, 32'd12, 3'b000);
    op_chk("R3 add keeps carry", OP_ADD, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0, 32'd0, 3'b000);
    op_chk("R1 addi", OP_ADDI, 32'd100, 32'd0, 32'hFFFF_FFF6, 1'b0, 32'd90, 3'b000);
    op_chk("R3 addic carry", OP_ADDIC, 32'd100, 32'd0, 32'hFFFF_FFF6, 1'b0, 32'd90, 3'b001);
    op_chk("R3 addc clears carry", OP_ADDC, 32'd1, 32'd2, 32'd0, 1'b0, 32'd3, 3'b000);
    op_chk("R3 addc carry out", OP_ADDC, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R4 adde consumes carry", OP_ADDE, 32'd1, 32'd2, 32'd0, 1'b0, 32'd4, 3'b000);
    op_chk("R3 addc set", OP_ADDC, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R4 adde equal case", OP_ADDE, 32'd5, 32'hFFFF_FFFF, 32'd0, 1'b0, 32'd5, 3'b001);
    op_chk("R1 addme ca1", OP_ADDME, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R3 addc zero", OP_ADDC, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 3'b000);
    op_chk("R1 addme ca0", OP_ADDME, 32'd0, 32'd0, 32'd0, 1'b0, 32'hFFFF_FFFF, 3'b000);
    op_chk("R1 addze ca0", OP_ADDZE, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, 32'hFFFF_FFFF, 3'b000);
    op_chk("R3 addc set2", OP_ADDC, 32'd1, 32'hFFFF_FFFF, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R1 addze ca1", OP_ADDZE, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, 32'd0, 3'b001);
  endtask

  task automatic t_sub_family;
    clear_flags();
    op_chk("R2 subf", OP_SUBF, 32'd3, 32'd10, 32'd0, 1'b0, 32'd7, 3'b000);
    op_chk("R3 subfc no borrow", OP_SUBFC, 32'd3, 32'd10, 32'd0, 1'b0, 32'd7, 3'b001);
    op_chk("R3 subfc borrow", OP_SUBFC, 32'd10, 32'd3, 32'd0, 1'b0, 32'hFFFF_FFF9, 3'b000);
    op_chk("R2 subfe ca0", OP_SUBFE, 32'd3, 32'd10, 32'd0, 1'b0, 32'd6, 3'b001);
    op_chk("R2 subfic", OP_SUBFI, 32'd1, 32'd0, 32'd100, 1'b0, 32'd99, 3'b001);
    op_chk("R2 subfze ca1", OP_SUBFZE, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R2 subfme ca1", OP_SUBFME, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R3 subfc equal", OP_SUBFC, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 3'b001);
  endtask

  task automatic t_overflow;
    clear_flags();
    issue(OP_ADD, 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b1, 1'b1, 1'b1);
    chk("R7 record negative with so", {28'd0, rec_o}, 32'h9);
    commit();
    chk("R5 overflow sets ov and so", {29'd0, sumovf_o, ovf_o, carry_o}, 32'b110);
    op_chk("R5 oe off keeps ov", OP_ADD, 32'd1, 32'd1, 32'd0, 1'b0, 32'd2, 3'b110);
    issue(OP_ADD, 32'd1, 32'd1, 32'd0, 1'b1, 1'b1, 1'b1);
    chk("R7 record positive with so", {28'd0, rec_o}, 32'h5);
    commit();
    chk("R5 ov clears, so sticky", {29'd0, sumovf_o, ovf_o, carry_o}, 32'b100);
    op_chk("R5 subf overflow", OP_SUBF, 32'd1, 32'h8000_0000, 32'd0, 1'b1, 32'h7FFF_FFFF, 3'b110);
    issue(OP_FLGRD, '0, '0, '0, 1'b0, 1'b0, 1'b1);
    chk("R8 read so ov", result_o, 32'hC);
    commit();
  endtask

  task automatic t_negate;
    clear_flags();
    op_chk("R6 neg", OP_NEG, 32'd5, 32'd0, 32'd0, 1'b0, 32'hFFFF_FFFB, 3'b000);
    op_chk("R6 neg min oe off", OP_NEG, 32'h8000_0000, 32'd0, 32'd0, 1'b0, 32'h8000_0000, 3'b000);
    op_chk("R6 neg zero", OP_NEG, 32'd0, 32'd0, 32'd0, 1'b1, 32'd0, 3'b000);
    op_chk("R6 neg min oe on", OP_NEG, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 32'h8000_0000, 3'b110);
  endtask

  task automatic t_flag_access;
    clear_flags();
    op_chk("R3 set carry", OP_ADDC, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0, 32'd0, 3'b001);
    op_chk("R5 set ov", OP_ADD, 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b1, 32'h8000_0000, 3'b111);
    op_chk("R8 read all flags", OP_FLGRD, 32'd0, 32'd0, 32'd0, 1'b1, 32'hE, 3'b111);
    op_chk("R9 clear all", OP_FLGCLR, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 3'b000);
    op_chk("R8 read cleared", OP_FLGRD, 32'd0, 32'd0, 32'd0, 1'b0, 32'd0, 3'b000);
  endtask

  task automatic t_idle_and_record;
    clear_flags();
    issue(OP_ADDC, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1, 1'b1, 1'b0);
    chk("R10 idle result still computed", result_o, 32'd0);
    chk("R7 record zero", {28'd0, rec_o}, 32'h2);
    @(posedge clk); #1;
    chk("R10 idle keeps flags", {29'd0, sumovf_o, ovf_o, carry_o}, 32'd0);
    issue(OP_ADD, 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b1, 1'b1, 1'b0);
    chk("R7 idle record so bit clear", {28'd0, rec_o}, 32'h8);
    @(posedge clk); #1;
    chk("R10 idle overflow ignored", {29'd0, sumovf_o, ovf_o, carry_o}, 32'd0);
    issue(OP_ADD, 32'd5, 32'd7, 32'd0, 1'b0, 1'b0, 1'b1);
    chk("R7 record disabled", {28'd0, rec_o}, 32'h0);
    commit();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_add_family();
    t_sub_family();
    t_overflow();
    t_negate();
    t_flag_access();
    t_idle_and_record();
    repeat (2) @(posedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule